// File: doc/BRIEF.md
# Flash programming sequencer with sector erase

This block writes a run of 32-bit words into a flash device through a small register-style access port. The port has a data register, an address register that carries a handshake flag, and a flag readback from the device. On a start pulse the sequencer first reads an identification word from the device. From that word it picks a device profile, which sets the sector size and the configuration address that takes erase commands. It then raises a flash-enable output and turns write protection off. Next it programs the requested number of words at consecutive addresses, and issues a sector-erase command before any word whose address opens a new sector. Last, it turns write protection back on, lowers flash-enable and pulses done.

Every device access waits for the device to answer through the flag, and a cycle-count timeout limits that wait. A write or erase that times out ends the burst. The protection-restore write is still sent, and the error output stays high until the next start. A read that times out gives the fixed word 0xDEADDEAD, which then selects the default profile.

Data words arrive on a valid/ready stream. A word is taken on a clock edge where in_valid and in_ready are both high. in_ready is high only while the sequencer waits for the next word to program, so the source may hold in_valid high for as long as it likes. in_data must stay stable while in_valid is high and in_ready is low.

Top module: `flprog_seq`

## Requirements
- R1: During and right after reset, done, failed, fl_en, in_ready, fl_data_we and fl_addr_we are all low.
- R2: A write access drives fl_data_we for one cycle with the word on fl_wdata. In the next cycle it drives fl_addr_we with fl_flag_wr=1. The write completes when fl_flag reads 0. If fl_flag has not read 0 within WR_TMO cycles, the write fails. fl_cfg=1 selects the configuration space and fl_cfg=0 the data space.
- R3: A read access drives fl_addr_we with fl_flag_wr=0 and no data load. The word on fl_rdata is taken when fl_flag reads 1. If fl_flag has not read 1 within RD_TMO cycles, the read yields 0xDEADDEAD.
- R4: After start, the first access reads the data-space address ID_WORD_ADDR. If bits 7:0 of that word are 0xBF, the sector test mask is 0x1FFF and the sector mask is 0x3E000. The erase command then goes to configuration address 0x352 when bits 15:8 are 0x80, and to 0x3D8 otherwise. Any other word selects test mask 0x3FFF, sector mask 0x3C000 and erase address 0x3D8.
- R5: Before any erase or word write, the sequencer writes 0 to configuration address 0x101. The outcome of that write does not change the rest of the sequence.
- R6: Before the word at address A, when A AND the test mask is zero, the sequencer writes an erase command to the profile's erase address. Let f = (A AND sector mask) << 2. The command word is {0x00, f[7:0], f[15:8], f[23:16]}.
- R7: Stream words are written, in arrival order, to the data space at start_addr, start_addr+1, and so on. Exactly word_count words are taken. in_ready is high only inside a burst, while the sequencer waits for a word.
- R8: A failed erase or word write stops the burst. No further erase or word write is sent, no further stream word is taken, and failed goes high.
- R9: Every burst ends with a write of 0x9C to configuration address 0x101, including a burst that ended on an error.
- R10: fl_en is low during the identification read. It is high from the protection-off write through the protection-restore write, and low again when done pulses. done is high for exactly one cycle. failed holds its value until the next accepted start.
- R11: A word_count of 0 gives only the identification read, the protection-off write and the protection-restore write, then done with failed low.
- R12: A start pulse that arrives while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| start_addr | input | AW | First word address |
| word_count | input | CNT_W | Number of words to program |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Sequencer takes a word this cycle if valid |
| in_data | input | 32 | Stream word |
| done | output | 1 | One-cycle pulse at the end of a burst |
| failed | output | 1 | Burst aborted on a failed erase or write |
| fl_en | output | 1 | Flash write enable for the burst |
| fl_data_we | output | 1 | Load device data register |
| fl_wdata | output | 32 | Data register value |
| fl_addr_we | output | 1 | Write device address register (starts an access) |
| fl_addr | output | AW | Access address |
| fl_cfg | output | 1 | 1 = configuration space, 0 = data space |
| fl_flag_wr | output | 1 | Flag bit written with the address (1 = write, 0 = read) |
| fl_flag | input | 1 | Device flag readback |
| fl_rdata | input | 32 | Device read data |

## Verification
The assertions check the same things on every cycle. A write's address strobe always follows a data load with the flag set. Every write is issued while flash-enable is high. in_ready never rises outside a burst, and done is a single cycle with flash-enable low. Some behaviour only the bench scenarios can show: the full order of accesses for each profile, and the byte order of the erase payload across sector boundaries. They also show the fallback to the default profile after a read timeout, and that an aborted burst still restores protection while taking no further words.

// File: rtl/flprog_pkg.sv
package flprog_pkg;

  localparam int WORD_W = 32;

  // Access-port configuration space locations and values
  localparam logic [31:0] WP_REG_ADDR     = 32'h0000_0101;
  localparam logic [31:0] WP_OFF_VALUE    = 32'h0000_0000;
  localparam logic [31:0] WP_ON_VALUE     = 32'h0000_009C;
  localparam logic [31:0] ERASE_ADDR_STD  = 32'h0000_03D8;
  localparam logic [31:0] ERASE_ADDR_ALT  = 32'h0000_0352;

  // Sector geometry per profile
  localparam logic [31:0] REST_STD = 32'h0000_3FFF;
  localparam logic [31:0] SECT_STD = 32'h0003_C000;
  localparam logic [31:0] REST_ALT = 32'h0000_1FFF;
  localparam logic [31:0] SECT_ALT = 32'h0003_E000;

  // Identification word decode
  localparam logic [7:0] MAKER_ALT = 8'hBF;
  localparam logic [7:0] PART_ALT  = 8'h80;

  localparam logic [31:0] READ_FAIL_WORD = 32'hDEAD_DEAD;

  typedef enum logic [2:0] {
    PH_ID, PH_UNPROT, PH_ERASE, PH_WORD, PH_PROT
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_SCAN, S_TAKE, S_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {
    E_IDLE, E_DATA, E_ADDR, E_WAIT
  } eng_state_e;

endpackage

// File: rtl/flprog_access.sv
module flprog_access
  import flprog_pkg::*;
#(
  parameter int AW     = 20,
  parameter int RD_TMO = 16,
  parameter int WR_TMO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_cfg,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_data,
  output logic              done,
  output logic              ok,
  output logic [WORD_W-1:0] rdata,
  output logic              fl_data_we,
  output logic [WORD_W-1:0] fl_wdata,
  output logic              fl_addr_we,
  output logic [AW-1:0]     fl_addr,
  output logic              fl_cfg,
  output logic              fl_flag_wr,
  input  logic              fl_flag,
  input  logic [WORD_W-1:0] fl_rdata
);

  localparam int TMO_MAX = (RD_TMO > WR_TMO) ? RD_TMO : WR_TMO;
  localparam int TW      = $clog2(TMO_MAX + 1);
  localparam logic [TW-1:0] RD_LAST = TW'(RD_TMO - 1);
  localparam logic [TW-1:0] WR_LAST = TW'(WR_TMO - 1);

  eng_state_e        st;
  logic              wr_q, cfg_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] data_q;
  logic [TW-1:0]     cnt;
  logic              hit, last;

  assign hit  = wr_q ? !fl_flag : fl_flag;
  assign last = (cnt == (wr_q ? WR_LAST : RD_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      wr_q   <= 1'b0;
      cfg_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      ok     <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (req) begin
          wr_q   <= req_write;
          cfg_q  <= req_cfg;
          addr_q <= req_addr;
          data_q <= req_data;
          st     <= req_write ? E_DATA : E_ADDR;
        end
        E_DATA: st <= E_ADDR;
        E_ADDR: begin
          cnt <= '0;
          st  <= E_WAIT;
        end
        E_WAIT: begin
          if (hit) begin
            done <= 1'b1;
            ok   <= 1'b1;
            if (!wr_q) rdata <= fl_rdata;
            st   <= E_IDLE;
          end else if (last) begin
            done <= 1'b1;
            ok   <= 1'b0;
            if (!wr_q) rdata <= READ_FAIL_WORD;
            st   <= E_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign fl_data_we = (st == E_DATA);
  assign fl_wdata   = data_q;
  assign fl_addr_we = (st == E_ADDR);
  assign fl_addr    = addr_q;
  assign fl_cfg     = cfg_q;
  assign fl_flag_wr = wr_q;

  // R2: a data load is always followed by a write-flagged address strobe
  a_r2_load_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fl_data_we |=> (fl_addr_we && fl_flag_wr));

  // R2: a write-flagged address strobe always follows a data load
  a_r2_strobe_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_addr_we && fl_flag_wr) |-> $past(fl_data_we));

  // R2: completion is reported for one cycle only
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/flprog_sector.sv
module flprog_sector
  import flprog_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [15:0]       id_low,
  input  logic [AW-1:0]     addr,
  output logic              at_boundary,
  output logic [AW-1:0]     erase_addr,
  output logic [WORD_W-1:0] erase_word
);

  logic              alt;
  logic [WORD_W-1:0] rest_m, sect_m, a_ext, f;

  always_comb begin
    alt         = (id_low[7:0] == MAKER_ALT);
    rest_m      = alt ? REST_ALT : REST_STD;
    sect_m      = alt ? SECT_ALT : SECT_STD;
    erase_addr  = (alt && id_low[15:8] == PART_ALT) ? AW'(ERASE_ADDR_ALT)
                                                    : AW'(ERASE_ADDR_STD);
    a_ext       = WORD_W'(addr);
    at_boundary = ((a_ext & rest_m) == '0);
    f           = (a_ext & sect_m) << 2;
    erase_word  = {8'h00, f[7:0], f[15:8], f[23:16]};
  end

endmodule

// File: rtl/flprog_seq.sv
module flprog_seq
  import flprog_pkg::*;
#(
  parameter int          AW           = 20,
  parameter int          CNT_W        = 16,
  parameter int          RD_TMO       = 16,
  parameter int          WR_TMO       = 64,
  parameter logic [31:0] ID_WORD_ADDR = 32'h000D_03AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              done,
  output logic              failed,
  output logic              fl_en,
  output logic              fl_data_we,
  output logic [WORD_W-1:0] fl_wdata,
  output logic              fl_addr_we,
  output logic [AW-1:0]     fl_addr,
  output logic              fl_cfg,
  output logic              fl_flag_wr,
  input  logic              fl_flag,
  input  logic [WORD_W-1:0] fl_rdata
);

  localparam logic [AW-1:0] ID_A = AW'(ID_WORD_ADDR);
  localparam logic [AW-1:0] WP_A = AW'(WP_REG_ADDR);

  seq_state_e        st;
  phase_e            ph;
  logic [AW-1:0]     cur_addr;
  logic [CNT_W-1:0]  remain;
  logic [WORD_W-1:0] id_word;
  logic              err_q, en_q;
  logic              cmd_wr, cmd_cfg;
  logic [AW-1:0]     cmd_addr;
  logic [WORD_W-1:0] cmd_data;

  logic              e_done, e_ok;
  logic [WORD_W-1:0] e_rdata;
  logic              at_bnd;
  logic [AW-1:0]     er_addr;
  logic [WORD_W-1:0] er_word;
  logic              unused_id_hi;

  assign unused_id_hi = ^id_word[31:16];

  flprog_access #(.AW(AW), .RD_TMO(RD_TMO), .WR_TMO(WR_TMO)) u_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (st == S_ISSUE),
    .req_write  (cmd_wr),
    .req_cfg    (cmd_cfg),
    .req_addr   (cmd_addr),
    .req_data   (cmd_data),
    .done       (e_done),
    .ok         (e_ok),
    .rdata      (e_rdata),
    .fl_data_we (fl_data_we),
    .fl_wdata   (fl_wdata),
    .fl_addr_we (fl_addr_we),
    .fl_addr    (fl_addr),
    .fl_cfg     (fl_cfg),
    .fl_flag_wr (fl_flag_wr),
    .fl_flag    (fl_flag),
    .fl_rdata   (fl_rdata)
  );

  flprog_sector #(.AW(AW)) u_sector (
    .id_low      (id_word[15:0]),
    .addr        (cur_addr),
    .at_boundary (at_bnd),
    .erase_addr  (er_addr),
    .erase_word  (er_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= PH_ID;
      cur_addr <= '0;
      remain   <= '0;
      id_word  <= '0;
      err_q    <= 1'b0;
      en_q     <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_cfg  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur_addr <= start_addr;
          remain   <= word_count;
          err_q    <= 1'b0;
          ph       <= PH_ID;
          cmd_wr   <= 1'b0;
          cmd_cfg  <= 1'b0;
          cmd_addr <= ID_A;
          cmd_data <= '0;
          st       <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (e_done) begin
          case (ph)
            PH_ID: begin
              id_word  <= e_rdata;
              en_q     <= 1'b1;
              ph       <= PH_UNPROT;
              cmd_wr   <= 1'b1;
              cmd_cfg  <= 1'b1;
              cmd_addr <= WP_A;
              cmd_data <= WP_OFF_VALUE;
              st       <= S_ISSUE;
            end
            PH_UNPROT: st <= S_SCAN;
            PH_ERASE: begin
              if (e_ok) begin
                st <= S_TAKE;
              end else begin
                err_q    <= 1'b1;
                ph       <= PH_PROT;
                cmd_wr   <= 1'b1;
                cmd_cfg  <= 1'b1;
                cmd_addr <= WP_A;
                cmd_data <= WP_ON_VALUE;
                st       <= S_ISSUE;
              end
            end
            PH_WORD: begin
              if (e_ok) begin
                cur_addr <= cur_addr + 1'b1;
                remain   <= remain - 1'b1;
                st       <= S_SCAN;
              end else begin
                err_q    <= 1'b1;
                ph       <= PH_PROT;
                cmd_wr   <= 1'b1;
                cmd_cfg  <= 1'b1;
                cmd_addr <= WP_A;
                cmd_data <= WP_ON_VALUE;
                st       <= S_ISSUE;
              end
            end
            default: begin
              en_q <= 1'b0;
              st   <= S_FINISH;
            end
          endcase
        end
        S_SCAN: begin
          if (remain == '0) begin
            ph       <= PH_PROT;
            cmd_wr   <= 1'b1;
            cmd_cfg  <= 1'b1;
            cmd_addr <= WP_A;
            cmd_data <= WP_ON_VALUE;
            st       <= S_ISSUE;
          end else if (at_bnd) begin
            ph       <= PH_ERASE;
            cmd_wr   <= 1'b1;
            cmd_cfg  <= 1'b1;
            cmd_addr <= er_addr;
            cmd_data <= er_word;
            st       <= S_ISSUE;
          end else begin
            st <= S_TAKE;
          end
        end
        S_TAKE: if (in_valid) begin
          ph       <= PH_WORD;
          cmd_wr   <= 1'b1;
          cmd_cfg  <= 1'b0;
          cmd_addr <= cur_addr;
          cmd_data <= in_data;
          st       <= S_ISSUE;
        end
        S_FINISH: st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign in_ready = (st == S_TAKE);
  assign done     = (st == S_FINISH);
  assign failed   = err_q;
  assign fl_en    = en_q;

  // R10: done only ever pulses with the flash enable already dropped
  a_r10_done_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fl_en);

  // R7: stream words are only taken inside an enabled burst
  a_r7_ready_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> fl_en);

  // R2: every write-flagged access happens with the flash enabled
  a_r2_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_addr_we && fl_flag_wr) |-> fl_en);

endmodule

// File: tb/flprog_seq_bench.sv
`timescale 1ns/1ps
module flprog_seq_bench;

  localparam int AW     = 20;
  localparam int CNT_W  = 16;
  localparam int RD_TMO = 16;
  localparam int WR_TMO = 24;
  localparam int LAT    = 3;
  localparam int unsigned ID_A = 32'h000D_03AB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start = 1'b0;
  logic [AW-1:0]     start_addr = '0;
  logic [CNT_W-1:0]  word_count = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [31:0]       in_data = '0;
  logic              done, failed, fl_en;
  logic              fl_data_we, fl_addr_we, fl_cfg, fl_flag_wr;
  logic [31:0]       fl_wdata;
  logic [AW-1:0]     fl_addr;
  logic              m_flag;
  logic [31:0]       m_id = '0;
  logic [31:0]       m_data;

  flprog_seq #(.AW(AW), .CNT_W(CNT_W), .RD_TMO(RD_TMO), .WR_TMO(WR_TMO)) u_flprog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done(done), .failed(failed), .fl_en(fl_en),
    .fl_data_we(fl_data_we), .fl_wdata(fl_wdata), .fl_addr_we(fl_addr_we),
    .fl_addr(fl_addr), .fl_cfg(fl_cfg), .fl_flag_wr(fl_flag_wr),
    .fl_flag(m_flag), .fl_rdata(m_id)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit cond, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  int m_busy;
  int m_wr_idx;
  int hang_idx = -1;
  bit id_hang  = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag   <= 1'b1;
      m_busy   <= 0;
      m_wr_idx <= 0;
      m_data   <= '0;
    end else begin
      if (fl_data_we) m_data <= fl_wdata;
      if (fl_addr_we) begin
        if (fl_flag_wr) begin
          m_flag   <= 1'b1;
          m_busy   <= (m_wr_idx == hang_idx) ? 0 : LAT;
          m_wr_idx <= m_wr_idx + 1;
        end else begin
          m_flag <= 1'b0;
          m_busy <= id_hang ? 0 : LAT;
        end
      end else if (m_busy == 1) begin
        m_flag <= ~m_flag;
        m_busy <= 0;
      end else if (m_busy > 0) begin
        m_busy <= m_busy - 1;
      end
    end
  end

  // ---------------- expected access list and monitor ----------------
  typedef struct {
    bit          wr;
    bit          cfg;
    int unsigned addr;
    logic [31:0] data;
    bit          en;
    string       tag;
  } txn_t;

  txn_t exp_q[$];

  task automatic push_txn(input bit wr, input bit cfg, input int unsigned addr,
                          input logic [31:0] data, input bit en, input string tag);
    txn_t t;
    t.wr = wr; t.cfg = cfg; t.addr = addr; t.data = data; t.en = en; t.tag = tag;
    exp_q.push_back(t);
  endtask

  always @(negedge clk) begin : mon
    txn_t e;
    if (rst_n && fl_addr_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected access at addr", fl_addr, 0);
      end else begin
        e = exp_q.pop_front();
        check({fl_flag_wr, fl_cfg} == {e.wr, e.cfg}, e.tag, "access kind",
              {fl_flag_wr, fl_cfg}, {e.wr, e.cfg});
        check(fl_addr == e.addr[AW-1:0], e.tag, "access address", fl_addr, e.addr);
        if (e.wr)
          check(m_data == e.data, e.tag, "written word", m_data, e.data);
        check(fl_en == e.en, "R10", "flash enable at access", fl_en, e.en);
      end
    end
  end

  // ---------------- stream source ----------------
  logic [31:0] src_q[$];
  int  consumed = 0;
  bit  hs_pend  = 1'b0;
  bit  gap_on   = 1'b0;
  int  tick     = 0;

  always @(negedge clk) begin
    tick++;
    if (!rst_n) begin
      in_valid = 1'b0;
      hs_pend  = 1'b0;
    end else begin
      if (hs_pend) begin
        void'(src_q.pop_front());
        consumed++;
        in_valid = 1'b0;
      end
      if (!in_valid && src_q.size() > 0 && !(gap_on && (tick % 3 != 0)))
        in_valid = 1'b1;
      if (src_q.size() > 0) in_data = src_q[0];
      hs_pend = in_valid && in_ready;
    end
  end

  // ---------------- reference sequence builder ----------------
  function automatic void profile(input logic [31:0] id, output int unsigned rest,
                                  output int unsigned sect, output int unsigned eaddr);
    if (id[7:0] == 8'hBF) begin
      rest  = 32'h1FFF;
      sect  = 32'h3E000;
      eaddr = (id[15:8] == 8'h80) ? 32'h352 : 32'h3D8;
    end else begin
      rest  = 32'h3FFF;
      sect  = 32'h3C000;
      eaddr = 32'h3D8;
    end
  endfunction

  task automatic run(input string name, input logic [31:0] id, input bit idhang,
                     input int unsigned saddr, input int cnt, input int hang,
                     input bit gap, input bit poke);
    int unsigned rest, sect, eaddr;
    logic [31:0] idv;
    int w;
    bit experr;
    int expcons;
    int cyc;
    rst_n    = 1'b0;
    start    = 1'b0;
    exp_q.delete();
    src_q.delete();
    consumed = 0;
    hang_idx = hang;
    id_hang  = idhang;
    m_id     = id;
    gap_on   = gap;
    for (int i = 0; i < cnt; i++)
      src_q.push_back(32'h5A00_0000 ^ (saddr << 8) ^ (i * 32'h0103_0507));
    idv = idhang ? 32'hDEAD_DEAD : id;
    profile(idv, rest, sect, eaddr);
    push_txn(1'b0, 1'b0, ID_A, 32'h0, 1'b0, "R4");
    push_txn(1'b1, 1'b1, 32'h101, 32'h0, 1'b1, "R5");
    w = 1;
    experr  = 1'b0;
    expcons = 0;
    for (int i = 0; i < cnt; i++) begin
      int unsigned a;
      logic [31:0] f;
      a = saddr + i;
      if ((a & rest) == 0) begin
        f = (a & sect) << 2;
        push_txn(1'b1, 1'b1, eaddr, {8'h00, f[7:0], f[15:8], f[23:16]}, 1'b1, "R6");
        if (w == hang) begin experr = 1'b1; w++; break; end
        w++;
      end
      push_txn(1'b1, 1'b0, a, src_q[i], 1'b1, "R7");
      expcons++;
      if (w == hang) begin experr = 1'b1; w++; break; end
      w++;
    end
    push_txn(1'b1, 1'b1, 32'h101, 32'h9C, 1'b1, "R9");

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    start_addr = saddr[AW-1:0];
    word_count = cnt[CNT_W-1:0];
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin
        start_addr = 20'h00777;   // R12: must be ignored mid-burst
        word_count = 9;
        start      = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (cyc >= 20000) begin
      check(1'b0, "R10", {name, " done never seen"}, 0, 1);
    end else begin
      check(failed == experr, "R8", {name, " failed flag"}, failed, experr);
      check(exp_q.size() == 0, "R9", {name, " accesses left unseen"}, exp_q.size(), 0);
      check(consumed == expcons, "R7", {name, " stream words taken"}, consumed, expcons);
      check(!fl_en, "R10", {name, " enable low at done"}, fl_en, 0);
      check(!in_ready, "R7", {name, " ready low at done"}, in_ready, 0);
      @(negedge clk);
      check(!done, "R10", {name, " done pulse width"}, done, 0);
      check(failed == experr, "R10", {name, " failed held"}, failed, experr);
      if (cnt == 0)
        check(consumed == 0, "R11", {name, " empty burst takes nothing"}, consumed, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check(!done && !failed, "R1", "done/failed in reset", {done, failed}, 0);
    check(!fl_en && !in_ready, "R1", "enable/ready in reset", {fl_en, in_ready}, 0);
    check(!fl_data_we && !fl_addr_we, "R1", "strobes in reset", {fl_data_we, fl_addr_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !fl_en && !fl_addr_we, "R1", "idle after reset", {done, fl_en, fl_addr_we}, 0);

    run("std_profile_cross",  32'h0000_0013, 1'b0, 32'h3FFE,  4, -1, 1'b0, 1'b0); // R4 R6 R7
    run("alt_profile_352",    32'h0000_80BF, 1'b0, 32'h1FFF,  3, -1, 1'b1, 1'b0); // R4 R6
    run("alt_profile_3d8",    32'h0000_00BF, 1'b0, 32'h3E000, 2, -1, 1'b0, 1'b0); // R4 R6
    run("id_read_timeout",    32'h0000_80BF, 1'b1, 32'h0,     2, -1, 1'b1, 1'b0); // R3
    run("empty_burst",        32'h0000_0013, 1'b0, 32'h100,   0, -1, 1'b0, 1'b0); // R11
    run("erase_fails",        32'h0000_0013, 1'b0, 32'h8000,  3,  1, 1'b0, 1'b0); // R8 R9
    run("word_fails",         32'h0000_0013, 1'b0, 32'h100,   4,  3, 1'b1, 1'b0); // R2 R8
    run("unprotect_fails",    32'h0000_0013, 1'b0, 32'h4000,  2,  0, 1'b0, 1'b0); // R5
    run("start_while_busy",   32'h0000_0013, 1'b0, 32'h7FFC,  8, -1, 1'b1, 1'b1); // R12

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule